// File: doc/BRIEF.md
# Alias-Addressed Control and Status Register Bank

This block is a small register bank on a simple synchronous read/write bus. It holds three registers, and what an access does depends on which address alias is used. One status register can be read through two addresses. The plain address returns the status word and changes nothing. The clearing address returns the same word and then wipes the sticky error field. One control register is reached through three addresses: a plain read/write, an OR-in alias and an AND-in alias. One configuration register takes exactly one write after reset and then locks until the next reset.

The status word combines live identity inputs with four sticky error flags. Each error flag is set by a one-cycle pulse on its input. Read data is registered and appears one cycle after the read is accepted.

Top module: `scsr_top`

## Requirements
- R1: After reset the configuration register holds 0x000279E7, the control register holds 0, every sticky error bit is 0, and `busRdata` is 0.
- R2: A write to address 1 stores the write data in the control register. A read of address 1, 2 or 3 returns the control register.
- R3: A write to address 2 makes the control register equal to its old value ORed with the write data.
- R4: A write to address 3 makes the control register equal to its old value ANDed with the write data.
- R5: The first write to address 0 after reset stores the write data in the configuration register, and a read of address 0 returns it.
- R6: Every later write to address 0 is ignored until the next reset. A reset clears the lock, so address 0 can be written once again.
- R7: A read of address 4 returns the status word and leaves every sticky bit unchanged. The status word has `procId` in bits [2:0], `busMaster` in bits [6:4], `hostMaster` in bit 7, the sticky error flags in bits [19:16], and 0 in every other bit.
- R8: A read of address 5 returns the status word as it was before the read, and then clears bits [19:16].
- R9: A pulse on `errPulse[i]` sets status bit 16+i, which stays set until a clearing read or a reset. The flags are: bit 16, a broadcast read by another master; bit 17, a write to an uninitialised auto-DMA channel; bit 18, an access to SDRAM that is not initialised; bit 19, an illegal read from self through multiprocessor space.
- R10: An error pulse in the same cycle as a clearing read leaves its bit set after that read.
- R11: Read data is registered and is valid on the cycle after the read is accepted. It holds its value when there is no read. Addresses 6 to 15 read as 0. Writes to addresses 4 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe, one access per cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Register address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| procId | input | 3 | Processor identity shown in the status word |
| busMaster | input | 3 | Current bus master shown in the status word |
| hostMaster | input | 1 | Host-holds-bus flag shown in the status word |
| errPulse | input | 4 | One-cycle error event pulses |

## Verification
A register write takes effect at the clock edge that accepts it, so a read issued in the next cycle already sees the new value. Read data is due one edge after the read is accepted. A clearing read takes effect at the edge that captures its data, and an error pulse is taken in at the edge of the cycle in which it is driven. The bench drives every access on the falling edge and compares `busRdata` on the following falling edge. A reference model in the bench updates state only after it has computed the expected read value, so each expected value reflects the state before the access, as the hardware does.

// File: rtl/scsr_pkg.sv
package scsr_pkg;

  // Address map; the alias each code selects is what changes the behaviour.
  localparam int ADDR_CFG      = 0;
  localparam int ADDR_CTRL     = 1;
  localparam int ADDR_CTRL_SET = 2;
  localparam int ADDR_CTRL_CLR = 3;
  localparam int ADDR_STAT     = 4;
  localparam int ADDR_STAT_CLR = 5;

  // Status word layout.
  localparam int ID_W        = 3;
  localparam int ID_LSB      = 0;
  localparam int MASTER_LSB  = 4;
  localparam int HOST_BIT    = 7;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CFG  = 2'd1,
    SRC_CTRL = 2'd2,
    SRC_STAT = 2'd3
  } rdSrc_t;

  typedef struct packed {
    logic   cfgWr;
    logic   ctrlWr;
    logic   ctrlSet;
    logic   ctrlClr;
    logic   rdEn;
    rdSrc_t rdSrc;
    logic   statClr;
  } strobe_t;

endpackage

// File: rtl/scsr_ctrl.sv
module scsr_ctrl
  import scsr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  logic cfgLocked;
  logic doWr;
  logic doRd;

  assign doWr = busSel & busWr;
  assign doRd = busSel & ~busWr;

  // The lock is its own flag: only reset clears it, and the first accepted write to the configuration address sets it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLocked <= 1'b0;
    end else if (doWr && busAddr == ADDR_W'(ADDR_CFG)) begin
      cfgLocked <= 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.rdSrc   = SRC_NONE;
    stb.rdEn    = doRd;
    if (doWr) begin
      unique case (busAddr)
        ADDR_W'(ADDR_CFG):      stb.cfgWr   = ~cfgLocked;
        ADDR_W'(ADDR_CTRL):     stb.ctrlWr  = 1'b1;
        ADDR_W'(ADDR_CTRL_SET): stb.ctrlSet = 1'b1;
        ADDR_W'(ADDR_CTRL_CLR): stb.ctrlClr = 1'b1;
        default: ;
      endcase
    end
    if (doRd) begin
      unique case (busAddr)
        ADDR_W'(ADDR_CFG):      stb.rdSrc = SRC_CFG;
        ADDR_W'(ADDR_CTRL),
        ADDR_W'(ADDR_CTRL_SET),
        ADDR_W'(ADDR_CTRL_CLR): stb.rdSrc = SRC_CTRL;
        ADDR_W'(ADDR_STAT):     stb.rdSrc = SRC_STAT;
        ADDR_W'(ADDR_STAT_CLR): begin
          stb.rdSrc   = SRC_STAT;
          stb.statClr = 1'b1;
        end
        default: stb.rdSrc = SRC_NONE;
      endcase
    end
  end

  // R11: at most one register-changing strobe per cycle.
  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cfgWr, stb.ctrlWr, stb.ctrlSet, stb.ctrlClr, stb.statClr}));

  // R5: an accepted configuration write leaves the lock set.
  assert_lock_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr |=> cfgLocked);

  // R6: once set, the lock stays set until reset.
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgLocked |=> cfgLocked);

endmodule

// File: rtl/scsr_regs.sv
module scsr_regs
  import scsr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ERR_N    = 4,
  parameter int          ERR_LSB  = 16,
  parameter logic [31:0] CFG_INIT = 32'h0002_79E7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   procId,
  input  logic [ID_W-1:0]   busMaster,
  input  logic              hostMaster,
  input  logic [ERR_N-1:0]  errPulse,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] ctrlReg;
  logic [ERR_N-1:0]  stickyErr;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdMux;
  logic [ERR_N-1:0]  stickyNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= DATA_W'(CFG_INIT);
    end else if (stb.cfgWr) begin
      cfgReg <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (stb.ctrlWr) begin
      ctrlReg <= wdata;
    end else if (stb.ctrlSet) begin
      ctrlReg <= ctrlReg | wdata;
    end else if (stb.ctrlClr) begin
      ctrlReg <= ctrlReg & wdata;
    end
  end

  // A clearing read removes the old flags; a pulse arriving in the same cycle still lands.
  always_comb begin
    stickyNext = stb.statClr ? '0 : stickyErr;
    stickyNext = stickyNext | errPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyErr <= '0;
    end else begin
      stickyErr <= stickyNext;
    end
  end

  always_comb begin
    statusWord                        = '0;
    statusWord[ID_LSB +: ID_W]        = procId;
    statusWord[MASTER_LSB +: ID_W]    = busMaster;
    statusWord[HOST_BIT]              = hostMaster;
    statusWord[ERR_LSB +: ERR_N]      = stickyErr;
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_CFG:  rdMux = cfgReg;
      SRC_CTRL: rdMux = ctrlReg;
      SRC_STAT: rdMux = statusWord;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdEn) begin
      rdata <= rdMux;
    end
  end

  // R3: the OR-in alias keeps every bit that was already set and adds the written ones.
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlSet |=> ctrlReg == ($past(ctrlReg) | $past(wdata)));

  // R4: the AND-in alias can only remove bits.
  assert_clear_alias_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlClr |=> ctrlReg == ($past(ctrlReg) & $past(wdata)));

  // R6: without an accepted configuration write the register holds.
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cfgWr |=> $stable(cfgReg));

  // R7: a non-clearing cycle with no pulses leaves the flags as they were.
  assert_peek_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.statClr && errPulse == '0) |=> $stable(stickyErr));

  // R10: every pulsed flag is set after the edge, whatever the read did.
  assert_pulse_lands_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse != '0) |=> ((stickyErr & $past(errPulse)) == $past(errPulse)));

  // R11: no read, no change on the read bus.
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(rdata));

endmodule

// File: rtl/scsr_top.sv
module scsr_top
  import scsr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter int          ERR_N    = 4,
  parameter int          ERR_LSB  = 16,
  parameter logic [31:0] CFG_INIT = 32'h0002_79E7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [ID_W-1:0]   procId,
  input  logic [ID_W-1:0]   busMaster,
  input  logic              hostMaster,
  input  logic [ERR_N-1:0]  errPulse
);

  strobe_t stb;

  scsr_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  scsr_regs #(
    .DATA_W   (DATA_W),
    .ERR_N    (ERR_N),
    .ERR_LSB  (ERR_LSB),
    .CFG_INIT (CFG_INIT)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (busWdata),
    .procId     (procId),
    .busMaster  (busMaster),
    .hostMaster (hostMaster),
    .errPulse   (errPulse),
    .rdata      (busRdata)
  );

endmodule

// File: tb/scsr_top_test.sv
module scsr_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  procId = 3'd5;
  logic [2:0]  busMaster = 3'd2;
  logic        hostMaster = 1'b1;
  logic [3:0]  errPulse = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Reference model state.
  logic [31:0] mCfg;
  logic        mLock;
  logic [31:0] mCtrl;
  logic [3:0]  mSticky;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsr_top uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .procId(procId),
    .busMaster(busMaster), .hostMaster(hostMaster), .errPulse(errPulse)
  );

  function automatic logic [31:0] statusOf(logic [3:0] st);
    logic [31:0] w;
    w = '0;
    w[2:0]   = procId;
    w[6:4]   = busMaster;
    w[7]     = hostMaster;
    w[19:16] = st;
    return w;
  endfunction

  function automatic logic [31:0] expectRead(logic [3:0] a);
    case (a)
      4'd0:             return mCfg;
      4'd1, 4'd2, 4'd3: return mCtrl;
      4'd4, 4'd5:       return statusOf(mSticky);
      default:          return 32'h0;
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mCfg = 32'h0002_79E7; mLock = 1'b0; mCtrl = '0; mSticky = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; errPulse = '0;
    modelReset();
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // One bus access with optional error pulses in the same cycle; returns read data checked one edge later.
  task automatic access(bit wr, logic [3:0] a, logic [31:0] d, logic [3:0] ep, string tag);
    logic [31:0] exp;
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = d; errPulse = ep;
    exp = expectRead(a);
    if (wr) begin
      case (a)
        4'd0: if (!mLock) begin mCfg = d; mLock = 1'b1; end
        4'd1: mCtrl = d;
        4'd2: mCtrl = mCtrl | d;
        4'd3: mCtrl = mCtrl & d;
        default: ;
      endcase
    end
    if (!wr && a == 4'd5) mSticky = '0;
    mSticky = mSticky | ep;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; errPulse = '0;
    if (!wr) check(busRdata, exp, tag);
  endtask

  task automatic pulseOnly(logic [3:0] ep);
    @(negedge clk);
    errPulse = ep;
    mSticky = mSticky | ep;
    @(negedge clk);
    errPulse = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_0042));
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    check(busRdata, 32'h0, "R1 rdata after reset");
    access(0, 4'd0, 0, 0, "R1 cfg reset value");
    access(0, 4'd1, 0, 0, "R1 ctrl reset value");
    access(0, 4'd4, 0, 0, "R1 status after reset");

    // R2 plain write, R3 OR-in, R4 AND-in
    access(1, 4'd1, 32'hA5A5_0F0F, 0, "");
    access(0, 4'd1, 0, 0, "R2 ctrl plain write");
    access(1, 4'd2, 32'h0000_F000, 0, "");
    access(0, 4'd2, 0, 0, "R3 ctrl set alias");
    access(1, 4'd3, 32'hFFFF_00FF, 0, "");
    access(0, 4'd3, 0, 0, "R4 ctrl clear alias");

    // R9 pulses set sticky bits, R7 peek keeps them, R8 clearing read
    pulseOnly(4'b0101);
    access(0, 4'd4, 0, 0, "R9 sticky bits 16 and 18");
    access(0, 4'd4, 0, 0, "R7 peek leaves flags");
    pulseOnly(4'b0010);
    access(0, 4'd5, 0, 0, "R8 clearing read returns old value");
    access(0, 4'd4, 0, 0, "R8 flags cleared after clearing read");

    // R10 pulse coincident with clearing read
    pulseOnly(4'b0001);
    access(0, 4'd5, 0, 4'b1000, "R10 clearing read with coincident pulse");
    access(0, 4'd4, 0, 0, "R10 coincident flag survives");

    // R5 first write, R6 later writes ignored
    access(1, 4'd0, 32'h0000_1234, 0, "");
    access(0, 4'd0, 0, 0, "R5 first cfg write stored");
    access(1, 4'd0, 32'hFFFF_FFFF, 0, "");
    access(0, 4'd0, 0, 0, "R6 second cfg write ignored");

    // R11 status writes ignored, unmapped reads zero, rdata holds
    access(1, 4'd4, 32'hFFFF_FFFF, 0, "");
    access(1, 4'd9, 32'hFFFF_FFFF, 0, "");
    access(0, 4'd4, 0, 0, "R11 write to status ignored");
    access(0, 4'd1, 0, 0, "R11 ctrl untouched by unmapped write");
    access(0, 4'd15, 0, 0, "R11 unmapped read zero");
    held = busRdata;
    repeat (3) @(negedge clk);
    check(busRdata, held, "R11 rdata holds without read");

    // R6 reset clears the lock
    doReset();
    access(0, 4'd0, 0, 0, "R1 cfg back to reset value");
    access(1, 4'd0, 32'h0BAD_CAFE, 0, "");
    access(0, 4'd0, 0, 0, "R6 cfg writable again after reset");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0]  a;
      logic [3:0]  ep;
      int          pick;
      pick = $urandom_range(0, 7);
      a = (pick > 5) ? 4'($urandom_range(6, 15)) : 4'(pick);
      ep = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      if ($urandom_range(0, 7) == 0) begin
        procId = 3'($urandom_range(0, 7));
        busMaster = 3'($urandom_range(0, 7));
        hostMaster = 1'($urandom_range(0, 1));
      end
      access(1'($urandom_range(0, 1)), a, $urandom(), ep, "R2 R3 R4 R7 R8 R9 random read");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule